// File: doc/BRIEF.md
# Handheld Cartridge Bridge Controller

This block sits behind a controller-accessory port. It turns 32-byte block commands into either local register activity or byte accesses on an attached handheld-console cartridge. A command carries a 16-bit block address and a direction. The low five address bits are ignored, so every block starts on a 32-byte boundary. Address bits 15..12 pick the region. The block keeps four pieces of state: an enable flag, a 2-bit bank, a one-bit access mode and an 8-bit mode-changed flag. The flag is sticky and is cleared when it is read.

Command, write-data and read-data use valid/ready handshakes.
- A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle.
- Each write command takes exactly 32 bytes on the write stream.
- Each read command delivers exactly 32 bytes on the read stream. A byte moves on a cycle where both valid and ready are high.
- While `rd_ready` is low, `rd_valid` and `rd_data` hold.
- The block never withdraws valid before the byte is taken.

The cartridge side is a byte port. `cart_req` holds its address and data steady until the cartridge answers with `cart_ack`.

Top module: `cbr_bridge`

## Requirements
- R1: For a window access (address bits 15..12 in 0xC..0xF), the block makes 32 cartridge accesses, one after another. Beat i uses cartridge address {bank[1:0], cmd_addr[13:5], i[4:0]}. The low five command address bits have no effect.
- R2: A read of region 0x8 returns 32 bytes of 0x84 while enabled and 32 bytes of 0x00 while disabled.
- R3: A read of region 0xB while enabled returns 32 bytes of status.
  - With a cartridge present and mode 1, each byte is 0x89. With a cartridge present and mode 0, each byte is 0x80. With no cartridge, each byte is 0x40.
  - With a cartridge present, byte 0 is ORed with the mode-changed flag.
  - Every enabled status read clears the flag to 0x00.
- R4: After reset the block is disabled, the bank is 0, the mode is 0 and the mode-changed flag is 0x44. `busy` is low and `cmd_ready` is high.
- R5: A write to region 0x8 looks only at its first byte. 0xFE disables the block and 0x84 enables it. Any other value leaves the enable state as it was.
- R6: While enabled, a write to region 0xA loads the bank from bits 1..0 of the first byte. While disabled, the write has no effect.
- R7: While enabled, a write to region 0xB sets the mode to bit 0 of the first byte and sets the mode-changed flag to 0x04.
- R8: Window reads while disabled return 32 bytes of 0x00 and make no cartridge access. Window writes go to the cartridge whether or not the block is enabled.
- R9: Reads of region 0xB while disabled, and reads or writes of any other region, return 0x00 bytes (for reads) and leave all state unchanged.
- R10: `cart_req` holds `cart_addr`, `cart_we` and `cart_wdata` steady until `cart_ack`. A read byte offered on `rd_valid` holds until `rd_ready`.
- R11: `busy` rises on the cycle after a command is taken and stays high until the last byte transfer completes. No command is taken while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_addr | input | 16 | Block address, low five bits ignored |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte accepted by the consumer |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | A command is in progress |
| cart_present | input | 1 | A cartridge is attached |
| cart_req | output | 1 | Cartridge byte access request |
| cart_we | output | 1 | Access is a write |
| cart_addr | output | 16 | Cartridge byte address |
| cart_wdata | output | 8 | Cartridge write byte |
| cart_rdata | input | 8 | Cartridge read byte, taken with cart_ack |
| cart_ack | input | 1 | Cartridge completes the current access |

## Verification
The checker covers the cycle-level rules on every cycle.
- The cartridge request and the read byte stay stable under back-pressure.
- `busy` follows a taken command, and an idle block drives no stream or cartridge activity.
- The bank never moves while the block is disabled.
- The mode-changed flag only holds one of its three legal values.
- No cartridge read happens while the block is disabled.

The bench scenarios are needed for everything that depends on the data values.
- The fill bytes and the status byte with the flag ORed into byte 0.
- The clear-on-read sequence.
- The two magic enable values.
- The window address arithmetic across banks.
- Window writes reaching the cartridge while the block is disabled.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  localparam int CBR_ADDR_W    = 16;
  localparam int CBR_DATA_W    = 8;
  localparam int CBR_BLK_BYTES = 32;

  localparam logic [7:0] KEY_ENABLE   = 8'h84;
  localparam logic [7:0] KEY_DISABLE  = 8'hFE;
  localparam logic [7:0] STAT_MODE1   = 8'h89;
  localparam logic [7:0] STAT_MODE0   = 8'h80;
  localparam logic [7:0] STAT_NO_CART = 8'h40;
  localparam logic [7:0] FLAG_AT_RST  = 8'h44;
  localparam logic [7:0] FLAG_ON_SET  = 8'h04;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_ENABLE,
    RG_BANK,
    RG_STATUS,
    RG_WINDOW
  } region_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CFG_SINK,
    S_FILL_OUT,
    S_RD_REQ,
    S_RD_OUT,
    S_WR_IN,
    S_WR_REQ
  } seq_state_e;

  function automatic region_e region_of(input logic [3:0] nib);
    region_e r;
    case (nib)
      4'h8:                      r = RG_ENABLE;
      4'hA:                      r = RG_BANK;
      4'hB:                      r = RG_STATUS;
      4'hC, 4'hD, 4'hE, 4'hF:    r = RG_WINDOW;
      default:                   r = RG_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cbr_decode.sv
module cbr_decode
  import cbr_pkg::*;
#(
  parameter int ADDR_W = CBR_ADDR_W,
  parameter int DATA_W = CBR_DATA_W,
  parameter int BEAT_W = 5
) (
  input  logic [ADDR_W-1:BEAT_W]   addr_i,
  input  logic                     en_i,
  input  logic                     present_i,
  input  logic                     mode_i,
  input  logic [1:0]               bank_i,
  input  logic [DATA_W-1:0]        flag_i,
  output region_e                  region_o,
  output logic [DATA_W-1:0]        fill_o,
  output logic [DATA_W-1:0]        head_o,
  output logic [ADDR_W-BEAT_W-1:0] base_o
);

  logic [DATA_W-1:0] status_byte;

  assign region_o = region_of(addr_i[ADDR_W-1:ADDR_W-4]);

  // Window base: bank selects a 16 KB page, address bits 13..BEAT_W the block.
  assign base_o = {bank_i, addr_i[ADDR_W-3:BEAT_W]};

  always_comb begin
    if (!present_i)   status_byte = STAT_NO_CART;
    else if (mode_i)  status_byte = STAT_MODE1;
    else              status_byte = STAT_MODE0;
  end

  always_comb begin
    case (region_o)
      RG_ENABLE: fill_o = en_i ? KEY_ENABLE : '0;
      RG_STATUS: fill_o = en_i ? status_byte : '0;
      default:   fill_o = '0;
    endcase
  end

  assign head_o = (region_o == RG_STATUS && en_i && present_i) ? (fill_o | flag_i) : fill_o;

endmodule

// File: rtl/cbr_regs.sv
module cbr_regs
  import cbr_pkg::*;
#(
  parameter int DATA_W = CBR_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_clr_i,
  input  logic              cfg_we_i,
  input  region_e           cfg_region_i,
  input  logic [DATA_W-1:0] cfg_byte_i,
  output logic              en_o,
  output logic [1:0]        bank_o,
  output logic              mode_o,
  output logic [DATA_W-1:0] flag_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o   <= 1'b0;
      bank_o <= 2'd0;
      mode_o <= 1'b0;
      flag_o <= FLAG_AT_RST;
    end else begin
      if (stat_clr_i) flag_o <= '0;
      if (cfg_we_i) begin
        case (cfg_region_i)
          RG_ENABLE: begin
            if (cfg_byte_i == KEY_DISABLE)     en_o <= 1'b0;
            else if (cfg_byte_i == KEY_ENABLE) en_o <= 1'b1;
          end
          RG_BANK: if (en_o) bank_o <= cfg_byte_i[1:0];
          RG_STATUS: if (en_o) begin
            mode_o <= cfg_byte_i[0];
            flag_o <= FLAG_ON_SET;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/cbr_seq.sv
module cbr_seq
  import cbr_pkg::*;
#(
  parameter int ADDR_W    = CBR_ADDR_W,
  parameter int DATA_W    = CBR_DATA_W,
  parameter int BLK_BYTES = CBR_BLK_BYTES,
  parameter int BEAT_W    = $clog2(BLK_BYTES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid_i,
  input  logic                     cmd_write_i,
  output logic                     cmd_ready_o,
  output logic                     busy_o,
  input  region_e                  region_i,
  input  logic [DATA_W-1:0]        fill_i,
  input  logic [DATA_W-1:0]        head_i,
  input  logic [ADDR_W-BEAT_W-1:0] base_i,
  input  logic                     en_i,
  input  logic                     wr_valid_i,
  output logic                     wr_ready_o,
  input  logic [DATA_W-1:0]        wr_data_i,
  output logic                     rd_valid_o,
  input  logic                     rd_ready_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     cart_req_o,
  output logic                     cart_we_o,
  output logic [ADDR_W-1:0]        cart_addr_o,
  output logic [DATA_W-1:0]        cart_wdata_o,
  input  logic [DATA_W-1:0]        cart_rdata_i,
  input  logic                     cart_ack_i,
  output logic                     stat_clr_o,
  output logic                     cfg_we_o,
  output region_e                  cfg_region_o,
  output logic [DATA_W-1:0]        cfg_byte_o
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BLK_BYTES - 1);

  seq_state_e               state_q;
  region_e                  region_q;
  logic [DATA_W-1:0]        fill_q, head_q, hold_q;
  logic [ADDR_W-BEAT_W-1:0] base_q;
  logic [BEAT_W-1:0]        beat_q;
  logic                     last_beat, accept;

  assign last_beat   = (beat_q == LAST_BEAT);
  assign cmd_ready_o = (state_q == S_IDLE);
  assign busy_o      = (state_q != S_IDLE);
  assign accept      = cmd_valid_i && cmd_ready_o;

  assign wr_ready_o  = (state_q == S_CFG_SINK) || (state_q == S_WR_IN);
  assign rd_valid_o  = (state_q == S_FILL_OUT) || (state_q == S_RD_OUT);
  assign rd_data_o   = (state_q == S_FILL_OUT) ? ((beat_q == '0) ? head_q : fill_q) : hold_q;

  assign cart_req_o   = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
  assign cart_we_o    = (state_q == S_WR_REQ);
  assign cart_addr_o  = {base_q, beat_q};
  assign cart_wdata_o = hold_q;

  assign stat_clr_o   = accept && !cmd_write_i && (region_i == RG_STATUS) && en_i;
  assign cfg_we_o     = (state_q == S_CFG_SINK) && wr_valid_i && (beat_q == '0);
  assign cfg_region_o = region_q;
  assign cfg_byte_o   = wr_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      region_q <= RG_NONE;
      fill_q   <= '0;
      head_q   <= '0;
      hold_q   <= '0;
      base_q   <= '0;
      beat_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          region_q <= region_i;
          fill_q   <= fill_i;
          head_q   <= head_i;
          base_q   <= base_i;
          beat_q   <= '0;
          if (cmd_write_i)
            state_q <= (region_i == RG_WINDOW) ? S_WR_IN : S_CFG_SINK;
          else if (region_i == RG_WINDOW && en_i)
            state_q <= S_RD_REQ;
          else
            state_q <= S_FILL_OUT;
        end
        S_CFG_SINK: if (wr_valid_i) begin
          beat_q <= beat_q + BEAT_W'(1);
          if (last_beat) state_q <= S_IDLE;
        end
        S_FILL_OUT: if (rd_ready_i) begin
          beat_q <= beat_q + BEAT_W'(1);
          if (last_beat) state_q <= S_IDLE;
        end
        S_RD_REQ: if (cart_ack_i) begin
          hold_q  <= cart_rdata_i;
          state_q <= S_RD_OUT;
        end
        S_RD_OUT: if (rd_ready_i) begin
          beat_q  <= beat_q + BEAT_W'(1);
          state_q <= last_beat ? S_IDLE : S_RD_REQ;
        end
        S_WR_IN: if (wr_valid_i) begin
          hold_q  <= wr_data_i;
          state_q <= S_WR_REQ;
        end
        S_WR_REQ: if (cart_ack_i) begin
          beat_q  <= beat_q + BEAT_W'(1);
          state_q <= last_beat ? S_IDLE : S_WR_IN;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cbr_bridge.sv
module cbr_bridge
  import cbr_pkg::*;
#(
  parameter int ADDR_W    = CBR_ADDR_W,
  parameter int DATA_W    = CBR_DATA_W,
  parameter int BLK_BYTES = CBR_BLK_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  input  logic              cart_present,
  output logic              cart_req,
  output logic              cart_we,
  output logic [ADDR_W-1:0] cart_addr,
  output logic [DATA_W-1:0] cart_wdata,
  input  logic [DATA_W-1:0] cart_rdata,
  input  logic              cart_ack
);

  localparam int BEAT_W = $clog2(BLK_BYTES);

  region_e                  region_w, cfg_region_w;
  logic [DATA_W-1:0]        fill_w, head_w, flag_w, cfg_byte_w;
  logic [ADDR_W-BEAT_W-1:0] base_w;
  logic                     en_w, mode_w, stat_clr_w, cfg_we_w;
  logic [1:0]               bank_w;
  logic                     unused_low;

  // Block alignment: the low address bits never reach the decoder.
  assign unused_low = ^cmd_addr[BEAT_W-1:0];

  cbr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_decode (
    .addr_i    (cmd_addr[ADDR_W-1:BEAT_W]),
    .en_i      (en_w),
    .present_i (cart_present),
    .mode_i    (mode_w),
    .bank_i    (bank_w),
    .flag_i    (flag_w),
    .region_o  (region_w),
    .fill_o    (fill_w),
    .head_o    (head_w),
    .base_o    (base_w)
  );

  cbr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .stat_clr_i   (stat_clr_w),
    .cfg_we_i     (cfg_we_w),
    .cfg_region_i (cfg_region_w),
    .cfg_byte_i   (cfg_byte_w),
    .en_o         (en_w),
    .bank_o       (bank_w),
    .mode_o       (mode_w),
    .flag_o       (flag_w)
  );

  cbr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES), .BEAT_W(BEAT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid_i  (cmd_valid),
    .cmd_write_i  (cmd_write),
    .cmd_ready_o  (cmd_ready),
    .busy_o       (busy),
    .region_i     (region_w),
    .fill_i       (fill_w),
    .head_i       (head_w),
    .base_i       (base_w),
    .en_i         (en_w),
    .wr_valid_i   (wr_valid),
    .wr_ready_o   (wr_ready),
    .wr_data_i    (wr_data),
    .rd_valid_o   (rd_valid),
    .rd_ready_i   (rd_ready),
    .rd_data_o    (rd_data),
    .cart_req_o   (cart_req),
    .cart_we_o    (cart_we),
    .cart_addr_o  (cart_addr),
    .cart_wdata_o (cart_wdata),
    .cart_rdata_i (cart_rdata),
    .cart_ack_i   (cart_ack),
    .stat_clr_o   (stat_clr_w),
    .cfg_we_o     (cfg_we_w),
    .cfg_region_o (cfg_region_w),
    .cfg_byte_o   (cfg_byte_w)
  );

endmodule

// File: rtl/cbr_bridge_chk.sv
module cbr_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              busy,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              cart_req,
  input logic              cart_we,
  input logic [ADDR_W-1:0] cart_addr,
  input logic [DATA_W-1:0] cart_wdata,
  input logic              cart_ack,
  input logic              en_i,
  input logic [1:0]        bank_i,
  input logic [DATA_W-1:0] flag_i
);

  assert_cart_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_req && !cart_ack) |=> (cart_req && $stable(cart_addr) && $stable(cart_we) && $stable(cart_wdata)));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cart_req && !rd_valid && !wr_ready));

  assert_bank_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(bank_i));

  assert_flag_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i == 8'h00) || (flag_i == 8'h04) || (flag_i == 8'h44));

  assert_no_gated_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_req && !cart_we) |-> en_i);

endmodule

bind cbr_bridge cbr_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .busy       (busy),
  .wr_ready   (wr_ready),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .cart_req   (cart_req),
  .cart_we    (cart_we),
  .cart_addr  (cart_addr),
  .cart_wdata (cart_wdata),
  .cart_ack   (cart_ack),
  .en_i       (en_w),
  .bank_i     (bank_w),
  .flag_i     (flag_w)
);

// File: tb/test_cbr_bridge.sv
module test_cbr_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic        wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        cart_present = 1'b1;
  logic        cmd_ready, wr_ready, rd_valid, busy, cart_req, cart_we;
  logic [7:0]  rd_data, cart_wdata;
  logic [15:0] cart_addr;
  logic [7:0]  cart_rdata = '0;
  logic        cart_ack = 1'b0;

  int n_checks = 0, n_fail = 0;
  int acc_total = 0;
  logic [15:0] log_a [32];
  logic [7:0]  log_d [32];
  logic        log_w [32];
  logic [7:0]  rbuf [32];
  logic [7:0]  wbuf [32];
  logic [7:0]  ebuf [32];

  // reference model state
  logic       m_en = 1'b0, m_mode = 1'b0;
  logic [1:0] m_bank = 2'd0;
  logic [7:0] m_flag = 8'h44;

  always #10 clk = ~clk;  // 50 MHz

  cbr_bridge i_cbr_bridge (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_addr, .cmd_write,
    .wr_valid, .wr_ready, .wr_data, .rd_valid, .rd_ready, .rd_data,
    .busy, .cart_present, .cart_req, .cart_we, .cart_addr, .cart_wdata,
    .cart_rdata, .cart_ack
  );

  function automatic logic [7:0] cdat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // cartridge responder with random latency
  always @(posedge clk) begin
    if (!rst_n) cart_ack <= 1'b0;
    else if (cart_req && !cart_ack && ($urandom % 3 != 0)) begin
      cart_ack   <= 1'b1;
      cart_rdata <= cdat(cart_addr);
      log_a[acc_total % 32] <= cart_addr;
      log_d[acc_total % 32] <= cart_wdata;
      log_w[acc_total % 32] <= cart_we;
      acc_total <= acc_total + 1;
    end else cart_ack <= 1'b0;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [15:0] a, input bit w);
    case (a[15:12])
      4'h8: return w ? "R5" : "R2";
      4'hA: return w ? "R6" : "R9";
      4'hB: return w ? "R7" : (m_en ? "R3" : "R9");
      4'hC, 4'hD, 4'hE, 4'hF: return w ? "R8 R1" : "R8 R1 read";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a, input int i);
    logic [7:0] s;
    case (a[15:12])
      4'h8: return m_en ? 8'h84 : 8'h00;
      4'hB: begin
        if (!m_en) return 8'h00;
        if (!cart_present) return 8'h40;
        s = m_mode ? 8'h89 : 8'h80;
        return (i == 0) ? (s | m_flag) : s;
      end
      4'hC, 4'hD, 4'hE, 4'hF:
        return m_en ? cdat({m_bank, a[13:5], 5'(i)}) : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic issue(input logic [15:0] a, input bit w);
    @(negedge clk);
    cmd_addr = a; cmd_write = w; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy && !cmd_ready, "R11", "busy after accept", {busy, cmd_ready}, 2'b10);
  endtask

  task automatic do_read(input logic [15:0] a);
    int start, got, bad;
    string tag;
    bit win;
    tag = tag_of(a, 1'b0);
    win = (a[15:14] == 2'b11) && m_en;
    for (int i = 0; i < 32; i++) ebuf[i] = exp_rd(a, i);
    start = acc_total;
    issue(a, 1'b0);
    got = 0;
    while (got < 32) begin
      rd_ready = ($urandom % 4) != 0;
      if (rd_valid && rd_ready) begin rbuf[got] = rd_data; got++; end
      @(negedge clk);
    end
    rd_ready = 1'b0;
    while (busy) @(negedge clk);
    bad = -1;
    for (int i = 31; i >= 0; i--) if (rbuf[i] !== ebuf[i]) bad = i;
    if (bad < 0) check(1'b1, tag, "read data", 0, 0);
    else check(1'b0, tag, $sformatf("read byte %0d at 0x%0h", bad, a), rbuf[bad], ebuf[bad]);
    check(acc_total - start == (win ? 32 : 0), tag, "cart access count", acc_total - start, win ? 32 : 0);
    if (a[15:12] == 4'hB && m_en) m_flag = 8'h00;
  endtask

  task automatic do_write(input logic [15:0] a);
    int start, k, bad;
    string tag;
    tag = tag_of(a, 1'b1);
    start = acc_total;
    issue(a, 1'b1);
    k = 0;
    while (k < 32) begin
      wr_data = wbuf[k];
      wr_valid = ($urandom % 4) != 0;
      if (wr_valid && wr_ready) k++;
      @(negedge clk);
    end
    wr_valid = 1'b0;
    while (busy) @(negedge clk);
    if (a[15:14] == 2'b11) begin
      check(acc_total - start == 32, tag, "window write count", acc_total - start, 32);
      bad = -1;
      for (int i = 31; i >= 0; i--) begin
        int j;
        j = (start + i) % 32;
        if (log_a[j] !== {m_bank, a[13:5], 5'(i)} || log_d[j] !== wbuf[i] || log_w[j] !== 1'b1) bad = i;
      end
      if (bad < 0) check(1'b1, tag, "window write", 0, 0);
      else check(1'b0, tag, $sformatf("window write beat %0d addr", bad),
                 log_a[(start + bad) % 32], {m_bank, a[13:5], 5'(bad)});
    end else begin
      check(acc_total == start, tag, "no cart access on register write", acc_total - start, 0);
      case (a[15:12])
        4'h8: if (wbuf[0] == 8'hFE) m_en = 1'b0; else if (wbuf[0] == 8'h84) m_en = 1'b1;
        4'hA: if (m_en) m_bank = wbuf[0][1:0];
        4'hB: if (m_en) begin m_mode = wbuf[0][0]; m_flag = 8'h04; end
        default: ;
      endcase
    end
  endtask

  task automatic fill_wbuf(input logic [7:0] first);
    wbuf[0] = first;
    for (int i = 1; i < 32; i++) wbuf[i] = 8'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: reset state at the ports
    check(!busy && cmd_ready, "R4", "idle after reset", {busy, cmd_ready}, 2'b01);
    check(!rd_valid && !cart_req && !wr_ready, "R4", "quiet after reset",
          {rd_valid, cart_req, wr_ready}, 3'b000);
    do_read(16'h8000);                     // R2 disabled -> zeros
    fill_wbuf(8'h12); do_write(16'h8000);  // R5 non-key ignored
    do_read(16'h8000);
    fill_wbuf(8'h03); do_write(16'hA000);  // R6 ignored while disabled
    fill_wbuf(8'h55); do_write(16'hB000);  // R9-style ignore of mode while disabled
    do_read(16'hB000);                     // R9 disabled status -> zeros, flag kept
    fill_wbuf(8'h84); do_write(16'h8000);  // R5 enable
    do_read(16'hB000);                     // R4 R3: 0x80|0x44 then
    do_read(16'hB000);                     // R3 cleared
    do_read(16'hC01F);                     // R1 R4 bank 0, low bits ignored
    fill_wbuf(8'h03); do_write(16'hB000);  // R7 mode 1, flag 04
    do_read(16'hB000);
    cart_present = 1'b0;
    do_read(16'hB000);                     // R3 no cartridge
    cart_present = 1'b1;
    fill_wbuf(8'h02); do_write(16'hA000);  // R6 bank 2
    do_read(16'hE7E0);
    fill_wbuf(8'hFE); do_write(16'h8000);  // R5 disable
    fill_wbuf(8'h99); do_write(16'hD140);  // R8 write forwarded while disabled
    do_read(16'hF000);                     // R8 gated read
    do_read(16'h3000);                     // R9 undecoded
    fill_wbuf(8'h84); do_write(16'h9000);  // R9 undecoded write ignored
    do_read(16'h8000);
    for (int n = 0; n < 300; n++) begin
      logic [3:0] nib;
      logic [7:0] fb;
      case ($urandom % 12)
        0, 1: nib = 4'h8;
        2:    nib = 4'hA;
        3, 4: nib = 4'hB;
        5:    nib = 4'hC;
        6:    nib = 4'hD;
        7:    nib = 4'hE;
        8:    nib = 4'hF;
        9:    nib = 4'h0;
        10:   nib = 4'h9;
        default: nib = 4'h3;
      endcase
      case ($urandom % 5)
        0: fb = 8'hFE;
        1: fb = 8'h84;
        2: fb = 8'h01;
        3: fb = 8'h00;
        default: fb = 8'($urandom);
      endcase
      if ($urandom % 10 == 0) cart_present = ~cart_present;
      if ($urandom % 2 == 0) do_read({nib, 12'($urandom)});
      else begin fill_wbuf(fb); do_write({nib, 12'($urandom)}); end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule